// File: doc/BRIEF.md
# Cascadable 32-bit Period Timer

This block holds two 16-bit up-counters, each with its own period register, control register, prescaler and event flag. Software reaches every register through a small 16-bit register port. Each timer counts one of three sources: the fabric clock, the fabric clock while a gate input is high, or rising edges of an external clock input that is synchronised first. The selected source goes through a divider of 1, 8, 64 or 256. When a counter equals its period on a counting step, the counter restarts from zero and the timer raises its event flag. The flag stays set until software clears it, and it drives an interrupt request when its enable is set.

Setting the fuse bit in the low control register joins the pair into one 32-bit counter. The low counter forms the lower half, and the comparison is made against the high and low period registers taken together. Only the low control register and the low channel's clock and gate pins are used in this mode. The event is reported on the high flag. A holding register makes 32-bit accesses coherent. Reading the low counter copies the high counter into the holding register. Writing the low counter in fused mode loads the upper half from the holding register in the same cycle.

In gated mode the end of a gate pulse, and not a period match, raises the flag. This lets software measure how long a pulse lasted.

Top module: `casc_timer`

## Requirements
- R1: After reset, both counters, both control registers, the holding register and the interrupt register read 0, both period registers read 0xFFFF, and both irq outputs are 0.
- R2: Register addresses: 0 low count, 1 high count, 2 low period, 3 high period, 4 low control, 5 high control, 6 holding, 7 interrupt. In split mode (low control bit 3 = 0), each timer counts on its own. On a counting step where the count equals its period, the count becomes 0 and the timer's flag is set.
- R3: Control bits 5:4 set the divider to 1, 8, 64 or 256 (codes 00, 01, 10, 11). After the divider is cleared, m source ticks give floor(m/N) counting steps.
- R4: Control bit 1 = 1 selects rising edges of that channel's external clock pin, after a two-flop synchroniser. Bit 1 = 0 with bit 6 = 1 selects the fabric clock gated by the channel's gate pin. Both 0 selects the fabric clock on every cycle.
- R5: In gated mode the count advances on each cycle the synchronised gate is high. The flag is set when the synchronised gate falls. A period match wraps the count but does not set the flag.
- R6: With low control bit 3 = 1, the counters form one 32-bit value {high,low} compared with {high period, low period}. The match sets the high flag (interrupt bit 1), the low flag stays unchanged, and the high control register has no effect.
- R7: A read of address 0 copies the high count into the holding register. In fused mode a write to address 0 loads the low count from the data and the high count from the holding register in the same cycle. In split mode it loads the low count only.
- R8: Control bit 15 turns counting on. With it clear, the count holds its value. A write to a control register, or bit 15 being clear, clears that channel's divider.
- R9: Interrupt register bit 0 is the low flag, bit 1 the high flag, bit 2 the low enable, bit 3 the high enable. Flags stay set until written 0 at address 7, and irq[i] = flag i AND enable i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock, also the internal count source |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 3 | Register address |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (needed for the holding copy) |
| wrData | input | CW | Write data |
| rdData | output | CW | Read data, combinational from addr |
| extClkIn | input | 2 | External count clocks, bit 0 low channel, bit 1 high channel |
| gateIn | input | 2 | Gate pins, bit 0 low channel, bit 1 high channel |
| irq | output | 2 | Interrupt requests, bit 0 low, bit 1 high |

## Verification
A wrong count or divider phase changes the count value read after a run of known length. It also moves the cycle of the wrap by one step, and the flag shows that at the irq pin one cycle after the bad step. A stale holding register shows as a wrong upper half on the first fused read or load after the copy. A flag that drops or sets wrongly reaches irq on the next cycle. The bench sweeps periods, divider codes and run lengths, and computes each expected count and flag arithmetically from the number of source ticks.

// File: rtl/casc_timer_pkg.sv
package casc_timer_pkg;
  localparam int AW       = 3;
  localparam int PRE_W    = 8;
  localparam int ON_BIT   = 15;
  localparam int T32_BIT  = 3;
  localparam int GATE_BIT = 6;
  localparam int EXT_BIT  = 1;
  localparam int PS_LSB   = 4;

  localparam logic [AW-1:0] A_CNTLO = 3'd0;
  localparam logic [AW-1:0] A_CNTHI = 3'd1;
  localparam logic [AW-1:0] A_PERLO = 3'd2;
  localparam logic [AW-1:0] A_PERHI = 3'd3;
  localparam logic [AW-1:0] A_CTLLO = 3'd4;
  localparam logic [AW-1:0] A_CTLHI = 3'd5;
  localparam logic [AW-1:0] A_HOLD  = 3'd6;
  localparam logic [AW-1:0] A_INT   = 3'd7;

  typedef struct packed {
    logic [1:0] tick;
    logic       mode32;
    logic       ldLo;
    logic       ldHi;
    logic       ldPerLo;
    logic       ldPerHi;
  } dpStrobe_t;

  function automatic logic [PRE_W-1:0] preLimit(input logic [1:0] sel);
    case (sel)
      2'b00:   preLimit = PRE_W'(0);
      2'b01:   preLimit = PRE_W'(7);
      2'b10:   preLimit = PRE_W'(63);
      default: preLimit = PRE_W'(255);
    endcase
  endfunction
endpackage

// File: rtl/casc_timer_sync.sv
module casc_timer_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/casc_timer_prescale.sv
module casc_timer_prescale
  import casc_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       clr,
  input  logic       srcTick,
  input  logic [1:0] sel,
  output logic       tickOut
);
  logic [PRE_W-1:0] divCnt;
  logic [PRE_W-1:0] limit;

  assign limit   = preLimit(sel);
  assign tickOut = srcTick && (divCnt == limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        divCnt <= '0;
    else if (clr)     divCnt <= '0;
    else if (srcTick) divCnt <= (divCnt == limit) ? '0 : divCnt + 1'b1;
  end
endmodule

// File: rtl/casc_timer_ctrl.sv
module casc_timer_ctrl
  import casc_timer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] addr,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [CW-1:0] wrData,
  output logic [CW-1:0] rdData,
  input  logic [1:0]    extClkIn,
  input  logic [1:0]    gateIn,
  input  logic [CW-1:0] cntLo,
  input  logic [CW-1:0] cntHi,
  input  logic [CW-1:0] perLo,
  input  logic [CW-1:0] perHi,
  input  logic [1:0]    match,
  output dpStrobe_t     st,
  output logic [CW-1:0] holdReg,
  output logic [CW-1:0] ctlLo,
  output logic [CW-1:0] ctlHi,
  output logic [1:0]    flags,
  output logic [1:0]    ens,
  output logic [1:0]    irq
);
  logic [1:0]         wrCtl;
  logic               wrHold, wrInt, rdLo, mode32;
  logic [1:0][CW-1:0] effCtl;
  logic [1:0]         extS, gateS, extP, gateP, extRise, gateFall;
  logic [1:0]         tickV, gatedV, setF;

  assign wrCtl[0] = wrEn && (addr == A_CTLLO);
  assign wrCtl[1] = wrEn && (addr == A_CTLHI);
  assign wrHold   = wrEn && (addr == A_HOLD);
  assign wrInt    = wrEn && (addr == A_INT);
  assign rdLo     = rdEn && (addr == A_CNTLO);
  assign mode32   = ctlLo[T32_BIT];
  assign effCtl[0] = ctlLo;
  assign effCtl[1] = ctlHi;

  casc_timer_sync #(.W(2)) u_extSync  (.clk(clk), .rstN(rstN), .d(extClkIn), .q(extS));
  casc_timer_sync #(.W(2)) u_gateSync (.clk(clk), .rstN(rstN), .d(gateIn),   .q(gateS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extP  <= '0;
      gateP <= '0;
    end else begin
      extP  <= extS;
      gateP <= gateS;
    end
  end

  assign extRise  = extS & ~extP;
  assign gateFall = gateP & ~gateS;

  for (genvar i = 0; i < 2; i++) begin : g_ch
    localparam bit IS_LO = (i == 0);
    logic chOn, src, preTick;

    assign chOn = effCtl[i][ON_BIT] && (IS_LO || !mode32);
    assign src  = effCtl[i][EXT_BIT]  ? extRise[i] :
                  effCtl[i][GATE_BIT] ? gateS[i]   : 1'b1;

    casc_timer_prescale u_pre (
      .clk    (clk),
      .rstN   (rstN),
      .clr    (!chOn || wrCtl[i]),
      .srcTick(src),
      .sel    (effCtl[i][PS_LSB +: 2]),
      .tickOut(preTick)
    );

    assign tickV[i]  = chOn && preTick;
    assign gatedV[i] = chOn && !effCtl[i][EXT_BIT] && effCtl[i][GATE_BIT];
  end

  assign setF[0] = !mode32 && (gatedV[0] ? gateFall[0] : match[0]);
  assign setF[1] = mode32 ? (gatedV[0] ? gateFall[0] : match[1])
                          : (gatedV[1] ? gateFall[1] : match[1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlLo   <= '0;
      ctlHi   <= '0;
      holdReg <= '0;
      flags   <= '0;
      ens     <= '0;
    end else begin
      if (wrCtl[0]) ctlLo <= wrData;
      if (wrCtl[1]) ctlHi <= wrData;
      if (wrHold)    holdReg <= wrData;
      else if (rdLo) holdReg <= cntHi;
      if (wrInt) ens <= wrData[3:2];
      flags <= (wrInt ? wrData[1:0] : flags) | setF;
    end
  end

  assign irq = flags & ens;

  always_comb begin
    st         = '0;
    st.tick    = tickV;
    st.mode32  = mode32;
    st.ldLo    = wrEn && (addr == A_CNTLO);
    st.ldHi    = wrEn && (addr == A_CNTHI);
    st.ldPerLo = wrEn && (addr == A_PERLO);
    st.ldPerHi = wrEn && (addr == A_PERHI);
  end

  always_comb begin
    case (addr)
      A_CNTLO: rdData = cntLo;
      A_CNTHI: rdData = cntHi;
      A_PERLO: rdData = perLo;
      A_PERHI: rdData = perHi;
      A_CTLLO: rdData = ctlLo;
      A_CTLHI: rdData = ctlHi;
      A_HOLD:  rdData = holdReg;
      default: rdData = {{(CW-4){1'b0}}, ens, flags};
    endcase
  end
endmodule

// File: rtl/casc_timer_dp.sv
module casc_timer_dp
  import casc_timer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     st,
  input  logic [CW-1:0] wrData,
  input  logic [CW-1:0] holdReg,
  output logic [CW-1:0] cntLo,
  output logic [CW-1:0] cntHi,
  output logic [CW-1:0] perLo,
  output logic [CW-1:0] perHi,
  output logic [1:0]    match
);
  localparam int DW = 2 * CW;

  logic          eqLo, eqHi, eqAll;
  logic [DW-1:0] wide;

  assign eqLo  = (cntLo == perLo);
  assign eqHi  = (cntHi == perHi);
  assign eqAll = eqLo && eqHi;
  assign wide  = {cntHi, cntLo};

  always_comb begin
    if (st.mode32) begin
      match[0] = 1'b0;
      match[1] = st.tick[0] && eqAll && !st.ldLo && !st.ldHi;
    end else begin
      match[0] = st.tick[0] && eqLo && !st.ldLo;
      match[1] = st.tick[1] && eqHi && !st.ldHi;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perLo <= '1;
      perHi <= '1;
    end else begin
      if (st.ldPerLo) perLo <= wrData;
      if (st.ldPerHi) perHi <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntLo <= '0;
      cntHi <= '0;
    end else if (st.mode32) begin
      if (st.ldLo) begin
        cntLo <= wrData;
        cntHi <= holdReg;
      end else if (st.ldHi) begin
        cntHi <= wrData;
      end else if (st.tick[0]) begin
        {cntHi, cntLo} <= eqAll ? '0 : wide + 1'b1;
      end
    end else begin
      if (st.ldLo)         cntLo <= wrData;
      else if (st.tick[0]) cntLo <= eqLo ? '0 : cntLo + 1'b1;
      if (st.ldHi)         cntHi <= wrData;
      else if (st.tick[1]) cntHi <= eqHi ? '0 : cntHi + 1'b1;
    end
  end
endmodule

// File: rtl/casc_timer.sv
module casc_timer
  import casc_timer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] addr,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [CW-1:0] wrData,
  output logic [CW-1:0] rdData,
  input  logic [1:0]    extClkIn,
  input  logic [1:0]    gateIn,
  output logic [1:0]    irq
);
  dpStrobe_t     st;
  logic [CW-1:0] cntLo, cntHi, perLo, perHi, holdReg, ctlLo, ctlHi;
  logic [1:0]    match, flags, ens;

  casc_timer_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .extClkIn(extClkIn), .gateIn(gateIn),
    .cntLo(cntLo), .cntHi(cntHi), .perLo(perLo), .perHi(perHi),
    .match(match), .st(st), .holdReg(holdReg), .ctlLo(ctlLo), .ctlHi(ctlHi),
    .flags(flags), .ens(ens), .irq(irq)
  );

  casc_timer_dp #(.CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .wrData(wrData), .holdReg(holdReg),
    .cntLo(cntLo), .cntHi(cntHi), .perLo(perLo), .perHi(perHi), .match(match)
  );
endmodule

// File: rtl/casc_timer_chk.sv
module casc_timer_chk
  import casc_timer_pkg::*;
#(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic [AW-1:0] addr,
  input logic          wrEn,
  input logic          rdEn,
  input logic [CW-1:0] wrData,
  input logic [CW-1:0] ctlLo,
  input logic [CW-1:0] ctlHi,
  input logic [CW-1:0] cntLo,
  input logic [CW-1:0] cntHi,
  input logic [CW-1:0] perLo,
  input logic [CW-1:0] holdReg,
  input logic [1:0]    flags
);
  a_r8_off_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlLo[ON_BIT] && !ctlHi[ON_BIT] && !wrEn) |=> ($stable(cntLo) && $stable(cntHi)));

  a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlLo[T32_BIT] && ctlLo[ON_BIT] && ctlLo[PS_LSB +: 2] == 2'b00 && !ctlLo[EXT_BIT]
     && !ctlLo[GATE_BIT] && !wrEn && cntLo == perLo) |=> (cntLo == '0));

  a_r6_lo_flag_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (ctlLo[T32_BIT] && !flags[0] && !wrEn) |=> !flags[0]);

  a_r9_flag_lo_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (flags[0] && !(wrEn && addr == A_INT)) |=> flags[0]);

  a_r9_flag_hi_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (flags[1] && !(wrEn && addr == A_INT)) |=> flags[1]);

  a_r7_fused_load: assert property (@(posedge clk) disable iff (!rstN)
    (ctlLo[T32_BIT] && wrEn && addr == A_CNTLO) |=>
      (cntHi == $past(holdReg) && cntLo == $past(wrData)));

  a_r7_hold_capture: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && addr == A_CNTLO) |=> (holdReg == $past(cntHi)));
endmodule

bind casc_timer casc_timer_chk #(.CW(CW)) u_chk (.*);

// File: tb/test_casc_timer.sv
`timescale 1ns/1ps
module test_casc_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  addr = '0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [15:0] wrData = '0, rdData;
  logic [1:0]  extClkIn = '0, gateIn = '0, irq;
  int nChk = 0, nFail = 0;
  bit done = 1'b0;

  casc_timer i_casc_timer (.clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .extClkIn(extClkIn), .gateIn(gateIn), .irq(irq));

  always #2.5 clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  function automatic int shiftOf(input int ps);
    case (ps)
      0: return 0;
      1: return 3;
      2: return 6;
      default: return 8;
    endcase
  endfunction

  // One split-mode run on channel ch: n idle cycles after start, stop write counts too
  task automatic runCh(input int ch, input int per, input int ps, input int n, input string req);
    logic [15:0] v, iv, v2;
    int t;
    wr(3'(4 + ch), 16'h0);
    wr(3'd7, 16'h0);
    wr(3'(ch), 16'h0);
    wr(3'(2 + ch), 16'(per));
    wr(3'(4 + ch), 16'h8000 | 16'(ps << 4));
    repeat (n) @(negedge clk);
    wr(3'(4 + ch), 16'(ps << 4));
    t = (n + 1) >> shiftOf(ps);
    rd(3'(ch), v);
    check(req, v, t % (per + 1));
    rd(3'd7, iv);
    check({req, " flag"}, iv[ch], (t > per) ? 1 : 0);
    repeat (8) @(negedge clk);
    rd(3'(ch), v2);
    check("R8 count held while off", v2, v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, hi, lo;
    int t;
    longint s, p, e;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1 reset register", v, (a == 2 || a == 3) ? 16'hFFFF : 16'h0);
    end
    check("R1 reset irq", irq, 0);

    // R2/R3 split-mode sweep on both channels
    wr(3'd4, 16'h0);
    for (int ch = 0; ch < 2; ch++)
      for (int pi = 0; pi < 3; pi++)
        for (int ps = 0; ps < 2; ps++)
          for (int ni = 0; ni < 3; ni++)
            runCh(ch, (pi == 0) ? 2 : (pi == 1) ? 5 : 9, ps, (ni == 0) ? 3 : (ni == 1) ? 7 : 20,
                  "R2 R3 split count");
    runCh(0, 1000, 2, 200, "R3 divide 64");
    runCh(1, 1000, 3, 600, "R3 divide 256");
    runCh(0, 1, 3, 600, "R3 divide 256 with wrap");

    // R2 both timers together with different periods
    wr(3'd7, 16'h000C);
    wr(3'd0, 0); wr(3'd1, 0); wr(3'd2, 4); wr(3'd3, 6);
    wr(3'd4, 16'h8000);
    wr(3'd5, 16'h8000);
    repeat (9) @(negedge clk);
    wr(3'd4, 0);
    wr(3'd5, 0);
    rd(3'd0, v); check("R2 parallel low", v, 11 % 5);
    rd(3'd1, v); check("R2 parallel high", v, 11 % 7);
    check("R9 irq both", irq, 2'b11);
    wr(3'd7, 16'h000C);
    rd(3'd7, v); check("R9 flags cleared", v, 16'h000C);
    check("R9 irq cleared", irq, 0);
    repeat (5) @(negedge clk);
    check("R9 irq stays clear", irq, 0);

    // R7 holding register
    wr(3'd1, 16'h1234);
    rd(3'd0, v);
    wr(3'd1, 16'h5678);
    rd(3'd6, v); check("R7 hold copy on low read", v, 16'h1234);
    wr(3'd6, 16'hAAAA);
    wr(3'd0, 16'h0007);
    rd(3'd1, v); check("R7 split write keeps high", v, 16'h5678);

    // R6 fused 32-bit mode, high control loaded with junk that must not matter
    for (int k = 0; k < 2; k++) begin
      wr(3'd4, 16'h0008);
      wr(3'd5, 16'h8070);
      wr(3'd7, 16'h0008);
      wr(3'd2, 16'h0003); wr(3'd3, 16'h0002);
      wr(3'd6, 16'h0001);
      wr(3'd0, 16'hFFFE);
      wr(3'd4, 16'h8008);
      repeat ((k == 0) ? 3 : 10) @(negedge clk);
      wr(3'd4, 16'h0008);
      t = (k == 0) ? 4 : 11;
      s = 64'h1FFFE; p = 64'h20003;
      e = s + t;
      if (e > p) e = (e - p - 1) % (p + 1);
      rd(3'd0, lo);
      rd(3'd6, hi);
      check("R6 R7 fused count", {hi, lo}, e);
      rd(3'd7, v);
      check("R6 high flag", v[1], (k == 1) ? 1 : 0);
      check("R6 low flag untouched", v[0], 0);
      check("R6 irq", irq, (k == 1) ? 2'b10 : 2'b00);
    end
    wr(3'd7, 16'h0);
    wr(3'd5, 16'h0);

    // R7 fused load takes upper half from holding register
    wr(3'd6, 16'hBEEF);
    wr(3'd0, 16'h0102);
    rd(3'd1, v); check("R7 fused load high", v, 16'hBEEF);
    rd(3'd0, v); check("R7 fused load low", v, 16'h0102);

    // R4/R5 gated mode, long period
    for (int g = 5; g < 14; g += 8) begin
      wr(3'd4, 16'h0); wr(3'd0, 0); wr(3'd2, 16'hFFFF);
      wr(3'd7, 16'h0004);
      wr(3'd4, 16'h8040);
      gateIn[0] = 1'b1;
      repeat (g) @(negedge clk);
      gateIn[0] = 1'b0;
      repeat (6) @(negedge clk);
      check("R5 irq at gate end", irq, 2'b01);
      wr(3'd4, 16'h0040);
      rd(3'd0, v); check("R4 R5 gated count", v, g);
    end

    // R5 period wrap in gated mode sets no flag
    wr(3'd4, 16'h0); wr(3'd0, 0); wr(3'd2, 3);
    wr(3'd7, 16'h0);
    wr(3'd4, 16'h8040);
    gateIn[0] = 1'b1;
    repeat (9) @(negedge clk);
    rd(3'd7, v); check("R5 no flag on gated wrap", v[0], 0);
    gateIn[0] = 1'b0;
    repeat (6) @(negedge clk);
    wr(3'd4, 16'h0040);
    rd(3'd0, v); check("R5 gated wrap count", v, 10 % 4);
    rd(3'd7, v); check("R5 flag after gate fall", v[0], 1);

    // R4 external clock, divide 1 and 8, on high channel too
    for (int ch = 0; ch < 2; ch++)
      for (int ps = 0; ps < 2; ps++) begin
        int m;
        m = (ps == 0) ? 5 : 17;
        wr(3'd4, 16'h0); wr(3'd5, 16'h0);
        wr(3'(ch), 0); wr(3'(2 + ch), 16'hFFFF);
        wr(3'(4 + ch), 16'h8002 | 16'(ps << 4));
        repeat (5) @(negedge clk);
        for (int q = 0; q < m; q++) begin
          extClkIn[ch] = 1'b1; repeat (2) @(negedge clk);
          extClkIn[ch] = 1'b0; repeat (2) @(negedge clk);
        end
        repeat (5) @(negedge clk);
        wr(3'(4 + ch), 16'h0);
        rd(3'(ch), v); check("R4 external edges", v, m >> shiftOf(ps));
      end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule